// File: doc/BRIEF.md
# Multi-Mode Timer Counter Core

This block is a 16-bit timer counter driven by a small register bus. Software sets a control word that selects the counting pattern. The pattern is up, down, or a triangle that runs up and down in one of three center variants. The control word also sets whether the reload limit is buffered, whether update events are masked or filtered, whether the counter stops itself after one period, and the period of a sampling tick for input filters. The counter runs off the core clock. It raises an update event each time it wraps or turns. On an update event it can copy a buffered reload limit into use and set a sticky update flag.

The bus has four word addresses: 0 is the control word, 1 is status and command, 2 is the counter and 3 is the reload limit. A write takes effect at the clock edge on which `bus_wr` is high. The block has no back-pressure, so a write is accepted on every cycle. Reads are combinational from `bus_raddr`. The outputs `cmp_ok_o` and `dir_o` tell compare logic outside the block when its flags may be raised.

Top module: `tmr_core`

## Requirements
- R1: After reset the control word, the counter, the reload limit and the flag all read 0. In the control word, bit 0 is run, bit 1 masks updates, bit 2 filters the flag source, bit 3 is one-shot, bit 4 is direction (1 = down), bits 6:5 select the alignment, bit 7 buffers the reload limit and bits 9:8 set the sampling division. All higher bits read 0.
- R2: With alignment 00 and direction 0, the running counter steps up by one on each clock. When it reaches the limit, it wraps to 0 and raises an update event. `upd_pulse_o` is high for the cycle after that wrap edge.
- R3: With alignment 00 and direction 1, the counter steps down. From 0 it reloads the limit and raises an update event.
- R4: With alignments 01, 10 and 11, the counter climbs to the limit, turns down (update event), falls to 0 and turns up (update event). Control bit 4 then reads the live direction, and writes to it are ignored.
- R5: `cmp_ok_o` is high only while running. In alignment 01 it is high only when counting down, in 10 only when counting up, and in 00 or 11 always.
- R6: A control write that asks for a center alignment is ignored in its alignment field while the alignment is 00 and run is 1. The rest of the write applies.
- R7: With one-shot set, the update event clears run and the counter holds. With one-shot clear, counting continues through the update event.
- R8: With buffering off, a write to address 3 is used at once. With buffering on, the written value is kept aside and is used only from the next update event. Address 3 reads back the last value written.
- R9: A write to address 3 made with buffering on, in the same cycle as an update event, is the value used from that event on.
- R10: While the update mask bit is set, the counter still wraps, but there is no update event, no pulse and no flag.
- R11: The update flag (status bit 0) stays set until software writes a 0 to status bit 0. A set in the same cycle wins. Writing 1 to status bit 1 makes a software update. With the filter bit (control bit 2) set, only a wrap or a turn sets the flag.
- R12: A software update restarts the counter: at the limit in alignment 00 with direction 1, otherwise at 0. Unless masked, it is an update event.
- R13: `smp_tick_o` fires every cycle for division codes 00 and 11, every 2nd cycle for 01 and every 4th cycle for 10.
- R14: A write to address 2 sets the counter. With run clear, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_waddr | input | 2 | Write word address |
| bus_wdata | input | 16 | Write data |
| bus_raddr | input | 2 | Read word address |
| bus_rdata | output | 16 | Read data, combinational |
| cnt_o | output | 16 | Live counter value |
| upd_pulse_o | output | 1 | One-cycle update event pulse |
| upd_flag_o | output | 1 | Sticky update flag |
| cmp_ok_o | output | 1 | Compare flags may be raised now |
| dir_o | output | 1 | Live counting direction, 1 = down |
| smp_tick_o | output | 1 | Filter sampling tick |

## Verification
Two things can fall in the same cycle: a software write of the reload limit while buffering is on, and the update event that moves the buffered limit into use. The bench gives the write on the exact clock edge on which the counter wraps. It then times the next period. The period matches the newly written limit, and the older buffered value has no effect.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_W = 10;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT    = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_RELOAD = 2'd3;

  typedef enum logic [1:0] {
    ALIGN_EDGE  = 2'b00,
    ALIGN_CDN   = 2'b01,
    ALIGN_CUP   = 2'b10,
    ALIGN_CBOTH = 2'b11
  } align_e;

  // packed so the bit positions match the control word
  typedef struct packed {
    logic [1:0] clkdiv;
    logic       rl_buf;
    align_e     align;
    logic       down;
    logic       one_shot;
    logic       src_sel;
    logic       upd_off;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              stop_i,
  input  logic              hw_down_i,
  output ctrl_t             cfg_o,
  output logic [CTRL_W-1:0] rd_o
);
  ctrl_t cfg_q, cfg_d, req;

  always_comb begin
    req   = ctrl_t'(wdata_i);
    cfg_d = cfg_q;
    if (wr_i) begin
      cfg_d = req;
      if (cfg_q.align == ALIGN_EDGE && cfg_q.run && req.align != ALIGN_EDGE)
        cfg_d.align = cfg_q.align;
      if (cfg_q.align != ALIGN_EDGE)
        cfg_d.down = cfg_q.down;
    end else if (stop_i) begin
      cfg_d.run = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    ctrl_t shown;
    shown      = cfg_q;
    shown.down = hw_down_i;
    rd_o       = CTRL_W'(shown);
  end

  assign cfg_o = cfg_q;

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && cfg_q.run && cfg_q.align == ALIGN_EDGE) |=> (cfg_q.align == ALIGN_EDGE)); // R6
  AST_ONE_SHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !wr_i) |=> !cfg_q.run); // R7
endmodule

// File: rtl/tmr_reload.sv
module tmr_reload #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             buf_i,
  input  logic             upd_i,
  output logic [CNT_W-1:0] pre_o,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] pre_q, act_q, act_d;

  always_comb begin
    act_d = act_q;
    if (wr_i && !buf_i) act_d = wdata_i;
    else if (upd_i)     act_d = wr_i ? wdata_i : pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) pre_q <= wdata_i;
      act_q <= act_d;
    end
  end

  assign pre_o = pre_q;
  assign act_o = act_q;

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_i && !upd_i) |=> $stable(act_q)); // R8
  AST_SHADOW_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_i && upd_i && wr_i) |=> (act_q == $past(wdata_i))); // R9
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  align_e           align_i,
  input  logic             down_cfg_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             reinit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             center, going_down, at_top, at_bot, step;

  always_comb begin
    center     = (align_i != ALIGN_EDGE);
    going_down = center ? dir_q : down_cfg_i;
    at_top     = (cnt_q >= limit_i);
    at_bot     = (cnt_q == '0);
    step       = run_i && !load_i && !reinit_i;
    wrap_o     = step && (going_down ? at_bot : at_top);
  end

  always_comb begin
    cnt_d = cnt_q;
    dir_d = center ? dir_q : down_cfg_i;
    if (reinit_i) begin
      cnt_d = (!center && down_cfg_i) ? limit_i : '0;
    end else if (load_i) begin
      cnt_d = load_val_i;
    end else if (run_i) begin
      if (!center) begin
        if (going_down) cnt_d = at_bot ? limit_i : cnt_q - ONE;
        else            cnt_d = at_top ? '0 : cnt_q + ONE;
      end else if (going_down) begin
        if (at_bot) begin
          cnt_d = (limit_i == '0) ? '0 : ONE;
          dir_d = 1'b0;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end else begin
        if (at_top) begin
          cnt_d = (limit_i == '0) ? '0 : limit_i - ONE;
          dir_d = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = going_down;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i && !reinit_i) |=> $stable(cnt_q)); // R14
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !center && !down_cfg_i && !at_top) |=> (cnt_q == $past(cnt_q) + ONE)); // R2
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !center && down_cfg_i && at_bot) |=> (cnt_q == $past(limit_i))); // R3
  AST_TURN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (step && center && !dir_q && at_top && align_i == $past(align_i)) |=> dir_q); // R4
endmodule

// File: rtl/tmr_smp_div.sv
module tmr_smp_div #(
  parameter int PRE_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pc_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    case (code_i)
      2'b01:   mask = PRE_W'(1);
      2'b10:   mask = PRE_W'(3);
      default: mask = '0;
    endcase
    tick_o = ((pc_q & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_q + PRE_W'(1);
  end

  AST_DIV4_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == 2'b10 && tick_o) |=> (!tick_o || code_i != 2'b10)); // R13
  AST_DIV1_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == 2'b00 || code_i == 2'b11) |-> tick_o); // R13
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              upd_pulse_o,
  output logic              upd_flag_o,
  output logic              cmp_ok_o,
  output logic              dir_o,
  output logic              smp_tick_o
);
  ctrl_t             cfg;
  logic [CTRL_W-1:0] ctrl_rd;
  logic              wr_ctrl, wr_stat, wr_cnt, wr_rl;
  logic              sw_upd, wrap, upd, stop, flag_set, flag_clr;
  logic              flag_q, pulse_q;
  logic [CNT_W-1:0]  rl_pre, rl_act, cnt;
  logic              live_down;

  assign wr_ctrl = bus_wr && (bus_waddr == ADR_CTRL);
  assign wr_stat = bus_wr && (bus_waddr == ADR_STAT);
  assign wr_cnt  = bus_wr && (bus_waddr == ADR_CNT);
  assign wr_rl   = bus_wr && (bus_waddr == ADR_RELOAD);

  assign sw_upd   = wr_stat && bus_wdata[1];
  assign upd      = (wrap || sw_upd) && !cfg.upd_off;
  assign stop     = upd && cfg.one_shot && cfg.run;
  assign flag_set = upd && (!cfg.src_sel || wrap);
  assign flag_clr = wr_stat && !bus_wdata[0];

  tmr_ctrl_reg u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_ctrl),
    .wdata_i   (bus_wdata[CTRL_W-1:0]),
    .stop_i    (stop),
    .hw_down_i (live_down),
    .cfg_o     (cfg),
    .rd_o      (ctrl_rd)
  );

  tmr_reload #(.CNT_W(CNT_W)) u_reload (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (wr_rl),
    .wdata_i (bus_wdata[CNT_W-1:0]),
    .buf_i   (cfg.rl_buf),
    .upd_i   (upd),
    .pre_o   (rl_pre),
    .act_o   (rl_act)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (cfg.run),
    .align_i    (cfg.align),
    .down_cfg_i (cfg.down),
    .limit_i    (rl_act),
    .load_i     (wr_cnt),
    .load_val_i (bus_wdata[CNT_W-1:0]),
    .reinit_i   (sw_upd),
    .cnt_o      (cnt),
    .dir_o      (live_down),
    .wrap_o     (wrap)
  );

  tmr_smp_div #(.PRE_W(PRE_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (cfg.clkdiv),
    .tick_o (smp_tick_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= upd;
      if (flag_set)      flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_raddr)
      ADR_CTRL: bus_rdata = DATA_W'(ctrl_rd);
      ADR_STAT: bus_rdata = DATA_W'(flag_q);
      ADR_CNT:  bus_rdata = DATA_W'(cnt);
      default:  bus_rdata = DATA_W'(rl_pre);
    endcase
  end

  always_comb begin
    case (cfg.align)
      ALIGN_CDN: cmp_ok_o = cfg.run && live_down;
      ALIGN_CUP: cmp_ok_o = cfg.run && !live_down;
      default:   cmp_ok_o = cfg.run;
    endcase
  end

  assign cnt_o       = cnt;
  assign upd_pulse_o = pulse_q;
  assign upd_flag_o  = flag_q;
  assign dir_o       = live_down;

  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_raddr == ADR_CTRL) |-> ((bus_rdata >> CTRL_W) == '0)); // R1
  AST_MASK_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.upd_off && !flag_q) |=> !flag_q); // R10
  AST_MASK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.upd_off) |=> !pulse_q); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_stat && !bus_wdata[0])) |=> flag_q); // R11
endmodule

// File: tb/tmr_core_bench.sv
module tmr_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_waddr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_raddr = '0;
  logic [15:0] bus_rdata, cnt_o;
  logic        upd_pulse_o, upd_flag_o, cmp_ok_o, dir_o, smp_tick_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tmr_core u_tmr_core (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .cnt_o(cnt_o), .upd_pulse_o(upd_pulse_o), .upd_flag_o(upd_flag_o),
    .cmp_ok_o(cmp_ok_o), .dir_o(dir_o), .smp_tick_o(smp_tick_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive a write; one clock edge passes; returns at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_raddr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clean(input logic [15:0] lim, input logic [15:0] c);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd3, lim);
    wr(2'd2, c);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); chk("R1 ctrl reset", v, 0);
    rd(2'd1, v); chk("R1 flag reset", v, 0);
    rd(2'd2, v); chk("R1 counter reset", v, 0);
    rd(2'd3, v); chk("R1 reload reset", v, 0);
    wr(2'd0, 16'hFFC0);
    rd(2'd0, v); chk("R1 high bits read zero", v >> 10, 0);
  endtask

  task automatic t_up();
    logic [15:0] v;
    clean(16'd3, 16'd0);
    wr(2'd0, 16'h0001);
    for (int k = 1; k <= 8; k++) begin
      step();
      chk("R2 up count", cnt_o, k % 4);
      chk("R2 up pulse", upd_pulse_o, (k % 4) == 0);
    end
    step(); step();
    chk("R11 flag sticky", upd_flag_o, 1);
    wr(2'd1, 16'h0000);
    rd(2'd1, v); chk("R11 flag cleared", v[0], 0);
  endtask

  task automatic t_down();
    logic [15:0] exp_c [7] = '{16'd1, 16'd0, 16'd3, 16'd2, 16'd1, 16'd0, 16'd3};
    clean(16'd3, 16'd2);
    wr(2'd0, 16'h0011);
    for (int k = 0; k < 7; k++) begin
      step();
      chk("R3 down count", cnt_o, exp_c[k]);
      chk("R3 down pulse", upd_pulse_o, (k == 2) || (k == 6));
    end
  endtask

  task automatic t_center();
    logic [15:0] v;
    logic [15:0] exp_c [10] = '{1, 2, 3, 2, 1, 0, 1, 2, 3, 2};
    logic        exp_d [10] = '{0, 0, 0, 1, 1, 1, 0, 0, 0, 1};
    clean(16'd3, 16'd0);
    wr(2'd0, 16'h0021);
    for (int k = 0; k < 10; k++) begin
      step();
      chk("R4 center count", cnt_o, exp_c[k]);
      chk("R4 center pulse", upd_pulse_o, (k == 3) || (k == 6) || (k == 9));
      chk("R5 qualifier mode 01", cmp_ok_o, exp_d[k]);
      if (k == 4) begin
        rd(2'd0, v); chk("R4 direction bit live", v[4], 1);
      end
    end
    // mode 10: qualifier only while rising
    clean(16'd3, 16'd0);
    wr(2'd0, 16'h0041);
    step(); chk("R5 qualifier mode 10 up", cmp_ok_o, 1);
    step(); step(); step();
    chk("R5 qualifier mode 10 down", cmp_ok_o, 0);
    // mode 11: qualifier both ways
    clean(16'd3, 16'd0);
    wr(2'd0, 16'h0061);
    step(); chk("R5 qualifier mode 11 up", cmp_ok_o, 1);
    step(); step(); step();
    chk("R5 qualifier mode 11 down", cmp_ok_o, 1);
    // direction write ignored in center
    clean(16'd3, 16'd0);
    wr(2'd0, 16'h0020);
    wr(2'd0, 16'h0030);
    rd(2'd0, v);
    chk("R4 direction write ignored", v[4], 0);
    chk("R4 center mode kept", v[6:5], 2'b01);
    chk("R5 qualifier off when stopped", cmp_ok_o, 0);
  endtask

  task automatic t_lock();
    logic [15:0] v;
    clean(16'd9, 16'd0);
    wr(2'd0, 16'h0001);
    wr(2'd0, 16'h0021);
    rd(2'd0, v); chk("R6 mode switch refused", v, 16'h0001);
    chk("R6 still counts up", cnt_o, 1);
    step();
    chk("R6 still counts up next", cnt_o, 2);
  endtask

  task automatic t_one_shot();
    logic [15:0] v;
    clean(16'd2, 16'd0);
    wr(2'd0, 16'h0009);
    step(); step(); step();
    chk("R7 wrap reached", cnt_o, 0);
    chk("R7 pulse", upd_pulse_o, 1);
    rd(2'd0, v); chk("R7 run cleared", v[0], 0);
    step(); step();
    chk("R7 counter holds", cnt_o, 0);
  endtask

  task automatic t_reload();
    logic [15:0] v;
    // immediate
    clean(16'd1, 16'd0);
    wr(2'd0, 16'h0001);
    step(); chk("R8 immediate limit", cnt_o, 1);
    step(); chk("R8 immediate wrap", cnt_o, 0);
    // buffered
    clean(16'd2, 16'd0);
    wr(2'd0, 16'h0080);
    wr(2'd3, 16'd5);
    rd(2'd3, v); chk("R8 readback written", v, 5);
    wr(2'd0, 16'h0081);
    step(); step(); step();
    chk("R8 old limit wraps", cnt_o, 0);
    chk("R8 old limit pulse", upd_pulse_o, 1);
    step(); step(); step();
    chk("R8 new limit in use", cnt_o, 3);
    step(); step(); step();
    chk("R8 new limit wraps", cnt_o, 0);
  endtask

  task automatic t_collide();
    clean(16'd2, 16'd0);
    wr(2'd0, 16'h0081);
    step(); step();
    wr(2'd3, 16'd4);
    chk("R9 wrap on write edge", upd_pulse_o, 1);
    step(); step(); step();
    chk("R9 forwarded limit used", cnt_o, 3);
    step(); chk("R9 reaches new top", cnt_o, 4);
    step(); chk("R9 wraps at new top", cnt_o, 0);
  endtask

  task automatic t_mask();
    logic [15:0] v;
    clean(16'd1, 16'd0);
    wr(2'd0, 16'h0003);
    step(); step();
    chk("R10 still wraps", cnt_o, 0);
    chk("R10 no pulse", upd_pulse_o, 0);
    rd(2'd1, v); chk("R10 no flag", v[0], 0);
  endtask

  task automatic t_sw_update();
    logic [15:0] v;
    clean(16'd6, 16'd3);
    wr(2'd1, 16'h0002);
    chk("R12 restart at zero", cnt_o, 0);
    rd(2'd1, v); chk("R11 software update sets flag", v[0], 1);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0004);
    wr(2'd2, 16'd3);
    wr(2'd1, 16'h0002);
    rd(2'd1, v); chk("R11 filtered source", v[0], 0);
    chk("R12 restart with filter", cnt_o, 0);
    wr(2'd0, 16'h0010);
    wr(2'd2, 16'd1);
    wr(2'd1, 16'h0003);
    chk("R12 down restart at limit", cnt_o, 6);
    wr(2'd2, 16'd7);
    step(); step(); step();
    chk("R14 counter holds when stopped", cnt_o, 7);
  endtask

  task automatic t_div();
    logic [15:0] codes [4] = '{16'h0000, 16'h0100, 16'h0200, 16'h0300};
    int          expn  [4] = '{8, 4, 2, 8};
    for (int c = 0; c < 4; c++) begin
      int n = 0;
      wr(2'd0, codes[c]);
      for (int k = 0; k < 8; k++) begin
        if (smp_tick_o) n++;
        step();
      end
      chk("R13 tick count", n, expn[c]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_center();
    t_lock();
    t_one_shot();
    t_reload();
    t_collide();
    t_mask();
    t_sw_update();
    t_div();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule